// File: doc/BRIEF.md
# Serial Interrupt Reporting Agent

This block is the peripheral end of a one-wire interrupt reporting scheme. It gathers sixteen legacy ISA-style interrupt request levels and four PCI interrupt levels and reports their state to a host over one shared open-drain line. Every transfer on the line is synchronous to the PCI clock. The host opens each packet with a start frame. A train of three-clock data slots follows, one slot per interrupt. The host then closes the packet with a stop frame, and the length of that stop frame picks the mode for the next packet.

A system-management interrupt request can take over the IRQ2 data slot when a configuration input selects it. A second configuration input appends the four PCI interrupt slots after the ISA slots. In continuous mode only the host starts packets. In quiet mode the agent may pull the idle line low for a single clock when a reported interrupt has changed, which asks the host to run a packet.

The line is modelled with separate sense and drive pins. `ser_in` is the sensed line level. When `ser_oe` is high the agent drives `ser_out`. When `ser_oe` is low the line floats and an external pull-up holds it high.

Top module: `serirq_agent`

## Requirements
- R1: After reset the agent releases the line (`ser_oe`=0) and is in continuous mode. A reset given while in quiet mode also returns it to continuous mode, so a later input change does not make it drive the line.
- R2: Timing of a start frame: the host holds the line low, then drives it high for one clock, then releases it. The clock after that release is the sample clock of slot 0. Slot k's sample clock comes 3k clocks after slot 0's. In that clock the agent pulls the line low if and only if slot k's interrupt is asserted (active-high input).
- R3: In the clock after a sample clock in which it drove low, the agent drives the line high (`ser_oe`=1, `ser_out`=1). In the clock after that it releases the line. It never drives in a slot whose interrupt is not asserted.
- R4: Slots 0 to 15 carry `irq_req[0]` to `irq_req[15]`. When `pci_slots_en`=1, slots 16 to 19 follow and carry `pci_int[0]` to `pci_int[3]`. When `pci_slots_en`=0 the packet holds only the 16 ISA slots.
- R5: When `smi_to_irq2`=1, slot 2 reports `smi_req` and `irq_req[2]` has no effect. When `smi_to_irq2`=0, slot 2 reports `irq_req[2]` and `smi_req` has no effect.
- R6: The agent counts the low clocks of the stop frame. Exactly two low clocks select quiet mode for what follows. Three or more low clocks select continuous mode.
- R7: In quiet mode, while idle, the agent pulls the line low for exactly one clock when any reported slot value differs from the value it sent in the last packet. It then releases the line. The self-start pulse comes one clock after the change reaches the inputs. Slots not in the packet (PCI slots when `pci_slots_en`=0) and unchanged inputs cause no pulse.
- R8: In continuous mode the agent never starts a packet by itself, whatever the inputs do.
- R9: The agent never drives the line during the start frame, the turnaround clock that follows it, or the stop frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock; every line transfer is synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | ISA-style interrupt request levels, active high |
| pci_int | input | 4 | PCI interrupt levels A to D, active high |
| smi_req | input | 1 | System-management interrupt request, active high |
| smi_to_irq2 | input | 1 | 1: slot 2 carries the system-management request |
| pci_slots_en | input | 1 | 1: append the four PCI interrupt slots |
| ser_in | input | 1 | Sensed level of the shared serial line |
| ser_oe | output | 1 | Drive enable for the serial line |
| ser_out | output | 1 | Value driven on the serial line when enabled |

## Verification
Both the sense input and the drive pins pass through one register stage. Because of this, a slot's value appears on the line in the third clock after the clock in which the host drives the start-frame recovery high (recovery, then turnaround, then sample). Its recovery-high clock and its release clock follow one and two clocks after that. A quiet-mode self-start pulse appears one clock after an input change. The new mode takes effect from the clock after the stop-frame recovery clock. The bench's host model moves its drive just after each rising edge and reads the line and `ser_oe` at the falling edge of exactly those clocks. It also checks that the line stays released in every clock of the start, turnaround and stop frames, and for several clocks after any input change that must not cause a self-start.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSIST,
        ST_START,
        ST_TA,
        ST_SLOT,
        ST_STOP
    } agent_state_e;

    typedef enum logic [1:0] {
        PH_SAMPLE,
        PH_RECOV,
        PH_TURN
    } slot_phase_e;

    typedef enum logic {
        MODE_CONT,
        MODE_QUIET
    } line_mode_e;

endpackage

// File: rtl/serirq_slot_mux.sv
module serirq_slot_mux #(
    parameter int NUM_ISA  = 16,
    parameter int NUM_PCI  = 4,
    parameter int SMI_SLOT = 2,
    localparam int NUM_SLOTS = NUM_ISA + NUM_PCI
) (
    input  logic [NUM_ISA-1:0]   irq_req,
    input  logic [NUM_PCI-1:0]   pci_int,
    input  logic                 smi_req,
    input  logic                 smi_to_irq2,
    input  logic                 pci_slots_en,
    output logic [NUM_SLOTS-1:0] slot_vec,
    output logic [NUM_SLOTS-1:0] slot_mask
);

    for (genvar i = 0; i < NUM_ISA; i++) begin : g_isa
        if (i == SMI_SLOT) begin : g_smi
            assign slot_vec[i] = smi_to_irq2 ? smi_req : irq_req[i];
        end else begin : g_plain
            assign slot_vec[i] = irq_req[i];
        end
        assign slot_mask[i] = 1'b1;
    end

    for (genvar j = 0; j < NUM_PCI; j++) begin : g_pci
        assign slot_vec[NUM_ISA+j]  = pci_int[j];
        assign slot_mask[NUM_ISA+j] = pci_slots_en;
    end

endmodule

// File: rtl/serirq_change_det.sv
module serirq_change_det #(
    parameter int WIDTH = 20
) (
    input  logic [WIDTH-1:0] slot_vec,
    input  logic [WIDTH-1:0] sent_vec,
    input  logic [WIDTH-1:0] slot_mask,
    output logic             changed
);

    logic [WIDTH-1:0] diff;

    always_comb begin
        diff    = (slot_vec ^ sent_vec) & slot_mask;
        changed = |diff;
    end

endmodule

// File: rtl/serirq_frame_fsm.sv
module serirq_frame_fsm
    import serirq_pkg::*;
#(
    parameter int NUM_ISA        = 16,
    parameter int NUM_PCI        = 4,
    parameter int STOP_CNT_W     = 3,
    parameter int QUIET_STOP_LEN = 2,
    localparam int NUM_SLOTS = NUM_ISA + NUM_PCI,
    localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    input  logic [NUM_SLOTS-1:0] slot_vec,
    input  logic                 pci_slots_en,
    input  logic                 changed,
    output logic                 ser_oe,
    output logic                 ser_out,
    output logic                 in_packet,
    output logic [NUM_SLOTS-1:0] sent_vec
);

    localparam logic [IDX_W-1:0]      LAST_ISA = IDX_W'(NUM_ISA - 1);
    localparam logic [IDX_W-1:0]      LAST_ALL = IDX_W'(NUM_SLOTS - 1);
    localparam logic [STOP_CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [STOP_CNT_W-1:0] CNT_QUIET = STOP_CNT_W'(QUIET_STOP_LEN);

    typedef struct packed {
        agent_state_e          st;
        slot_phase_e           ph;
        line_mode_e            mode;
        logic [IDX_W-1:0]      idx;
        logic [STOP_CNT_W-1:0] lowcnt;
        logic [NUM_SLOTS-1:0]  sent;
        logic                  oe;
        logic                  dout;
    } fsm_t;

    fsm_t s_d, s_q;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] nxt_idx;

    always_comb begin
        last_idx = pci_slots_en ? LAST_ALL : LAST_ISA;
        nxt_idx  = s_q.idx + 1'b1;
        s_d      = s_q;
        s_d.oe   = 1'b0;
        s_d.dout = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (!ser_in) begin
                    s_d.st = ST_START;
                end else if (s_q.mode == MODE_QUIET && changed) begin
                    s_d.st   = ST_ASSIST;
                    s_d.oe   = 1'b1;
                    s_d.dout = 1'b0;
                end
            end
            ST_ASSIST: begin
                s_d.st = ST_START;
            end
            ST_START: begin
                if (ser_in) begin
                    s_d.st = ST_TA;
                end
            end
            ST_TA: begin
                s_d.st      = ST_SLOT;
                s_d.ph      = PH_SAMPLE;
                s_d.idx     = '0;
                s_d.oe      = slot_vec[0];
                s_d.sent[0] = slot_vec[0];
            end
            ST_SLOT: begin
                unique case (s_q.ph)
                    PH_SAMPLE: begin
                        s_d.ph   = PH_RECOV;
                        s_d.oe   = s_q.oe;
                        s_d.dout = 1'b1;
                    end
                    PH_RECOV: begin
                        s_d.ph = PH_TURN;
                    end
                    default: begin
                        if (s_q.idx == last_idx) begin
                            s_d.st     = ST_STOP;
                            s_d.lowcnt = '0;
                        end else begin
                            s_d.idx           = nxt_idx;
                            s_d.ph            = PH_SAMPLE;
                            s_d.oe            = slot_vec[nxt_idx];
                            s_d.sent[nxt_idx] = slot_vec[nxt_idx];
                        end
                    end
                endcase
            end
            ST_STOP: begin
                if (!ser_in) begin
                    if (s_q.lowcnt != CNT_MAX) begin
                        s_d.lowcnt = s_q.lowcnt + 1'b1;
                    end
                end else if (s_q.lowcnt != '0) begin
                    s_d.st   = ST_IDLE;
                    s_d.mode = (s_q.lowcnt == CNT_QUIET) ? MODE_QUIET : MODE_CONT;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st     <= ST_IDLE;
            s_q.ph     <= PH_SAMPLE;
            s_q.mode   <= MODE_CONT;
            s_q.idx    <= '0;
            s_q.lowcnt <= '0;
            s_q.sent   <= '0;
            s_q.oe     <= 1'b0;
            s_q.dout   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_oe    = s_q.oe;
    assign ser_out   = s_q.dout;
    assign in_packet = (s_q.st == ST_TA) || (s_q.st == ST_SLOT);
    assign sent_vec  = s_q.sent;

endmodule

// File: rtl/serirq_agent.sv
module serirq_agent #(
    parameter int NUM_ISA        = 16,
    parameter int NUM_PCI        = 4,
    parameter int SMI_SLOT       = 2,
    parameter int STOP_CNT_W     = 3,
    parameter int QUIET_STOP_LEN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ISA-1:0] irq_req,
    input  logic [NUM_PCI-1:0] pci_int,
    input  logic               smi_req,
    input  logic               smi_to_irq2,
    input  logic               pci_slots_en,
    input  logic               ser_in,
    output logic               ser_oe,
    output logic               ser_out
);

    localparam int NUM_SLOTS = NUM_ISA + NUM_PCI;

    logic [NUM_SLOTS-1:0] slot_vec;
    logic [NUM_SLOTS-1:0] slot_mask;
    logic [NUM_SLOTS-1:0] sent_vec;
    logic                 changed;
    logic                 in_packet;

    serirq_slot_mux #(
        .NUM_ISA (NUM_ISA),
        .NUM_PCI (NUM_PCI),
        .SMI_SLOT(SMI_SLOT)
    ) u_mux (
        .irq_req     (irq_req),
        .pci_int     (pci_int),
        .smi_req     (smi_req),
        .smi_to_irq2 (smi_to_irq2),
        .pci_slots_en(pci_slots_en),
        .slot_vec    (slot_vec),
        .slot_mask   (slot_mask)
    );

    serirq_change_det #(
        .WIDTH(NUM_SLOTS)
    ) u_chg (
        .slot_vec (slot_vec),
        .sent_vec (sent_vec),
        .slot_mask(slot_mask),
        .changed  (changed)
    );

    serirq_frame_fsm #(
        .NUM_ISA       (NUM_ISA),
        .NUM_PCI       (NUM_PCI),
        .STOP_CNT_W    (STOP_CNT_W),
        .QUIET_STOP_LEN(QUIET_STOP_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_in      (ser_in),
        .slot_vec    (slot_vec),
        .pci_slots_en(pci_slots_en),
        .changed     (changed),
        .ser_oe      (ser_oe),
        .ser_out     (ser_out),
        .in_packet   (in_packet),
        .sent_vec    (sent_vec)
    );

endmodule

// File: rtl/serirq_agent_chk.sv
module serirq_agent_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_oe,
    input logic ser_out,
    input logic in_packet
);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ser_oe);

    // R3
    recovery_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && !ser_out && in_packet) |=> (ser_oe && ser_out));

    // R3
    turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && ser_out) |=> !ser_oe);

    // R7
    assist_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && !ser_out && !in_packet) |=> !ser_oe);

    // R9
    high_only_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && ser_out) |-> in_packet);

endmodule

bind serirq_agent serirq_agent_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_oe   (ser_oe),
    .ser_out  (ser_out),
    .in_packet(in_packet)
);

// File: tb/tb_serirq_agent.sv
module tb_serirq_agent;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;

    // fields: irq[42:27] pci[26:23] smi[22] sel[21] pen[20] expected slots[19:0]
    localparam logic [42:0] TBL [NVEC] = '{
        {16'h0000, 4'h0, 1'b0, 1'b0, 1'b1, 20'h00000},
        {16'hA5C3, 4'h9, 1'b0, 1'b0, 1'b1, 20'h9A5C3},
        {16'h0004, 4'h0, 1'b0, 1'b1, 1'b1, 20'h00000},
        {16'h0000, 4'hF, 1'b1, 1'b1, 1'b0, 20'h00004},
        {16'h8001, 4'h2, 1'b1, 1'b0, 1'b1, 20'h28001},
        {16'hFFFF, 4'hF, 1'b0, 1'b1, 1'b1, 20'hFFFFB},
        {16'h7FFE, 4'h4, 1'b0, 1'b0, 1'b0, 20'h07FFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [3:0]  pci_int = '0;
    logic        smi_req = 1'b0;
    logic        smi_to_irq2 = 1'b0;
    logic        pci_slots_en = 1'b1;
    logic        host_low = 1'b0;
    logic        ser_line;
    logic        ser_oe;
    logic        ser_out;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    assign ser_line = host_low ? 1'b0 : (ser_oe ? ser_out : 1'b1);

    always #(CLK_PERIOD/2) clk = ~clk;

    serirq_agent dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .pci_int     (pci_int),
        .smi_req     (smi_req),
        .smi_to_irq2 (smi_to_irq2),
        .pci_slots_en(pci_slots_en),
        .ser_in      (ser_line),
        .ser_oe      (ser_oe),
        .ser_out     (ser_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // host-side packet: start frame, slots, stop frame
    task automatic run_packet(input int start_len, input int stop_len, input int nslots,
                              output logic [19:0] got, output int bad_rec, output int bad_frame);
        got = '0;
        bad_rec = 0;
        bad_frame = 0;
        host_low = 1'b1;
        for (int i = 0; i < start_len; i++) begin
            @(negedge clk);
            if (ser_oe) bad_frame++;
            tick();
        end
        host_low = 1'b0;
        @(negedge clk);
        if (ser_oe) bad_frame++;
        tick();
        @(negedge clk);
        if (ser_oe) bad_frame++;
        tick();
        for (int k = 0; k < nslots; k++) begin
            @(negedge clk);
            got[k] = ~ser_line;
            tick();
            @(negedge clk);
            if (got[k] ? !(ser_oe && ser_out) : ser_oe) bad_rec++;
            tick();
            @(negedge clk);
            if (ser_oe) bad_rec++;
            tick();
        end
        host_low = 1'b1;
        for (int i = 0; i < stop_len; i++) begin
            @(negedge clk);
            if (ser_oe) bad_frame++;
            tick();
        end
        host_low = 1'b0;
        tick();
        tick();
    endtask

    task automatic count_drive(input int n, output int drives);
        drives = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ser_oe || !ser_line) drives++;
            tick();
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [19:0] got;
        int bad_rec;
        int bad_frame;
        int drives;

        repeat (3) tick();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset release", {31'd0, ser_oe}, 32'd0);
        tick();

        // R8: continuous mode, input change does not self-start
        irq_req = 16'h0010;
        count_drive(8, drives);
        check("R8 no self-start", drives, 0);

        // table of input patterns, continuous mode packets
        for (int v = 0; v < NVEC; v++) begin
            irq_req      = TBL[v][42:27];
            pci_int      = TBL[v][26:23];
            smi_req      = TBL[v][22];
            smi_to_irq2  = TBL[v][21];
            pci_slots_en = TBL[v][20];
            tick();
            run_packet(4, 3, pci_slots_en ? 20 : 16, got, bad_rec, bad_frame);
            check($sformatf("R2 R4 R5 slots vec%0d", v), {12'd0, got}, {12'd0, TBL[v][19:0]});
            check($sformatf("R3 recovery vec%0d", v), bad_rec, 0);
            check($sformatf("R9 frames vec%0d", v), bad_frame, 0);
        end

        // R6: stop of two lows selects quiet mode (16-slot packet)
        irq_req = 16'h0001; pci_int = 4'h0; smi_to_irq2 = 1'b0; pci_slots_en = 1'b0;
        tick();
        run_packet(5, 2, 16, got, bad_rec, bad_frame);
        check("R6 slots before quiet", {12'd0, got}, 32'h00001);

        // R7: unchanged inputs, no pulse
        count_drive(6, drives);
        check("R7 no pulse when unchanged", drives, 0);

        // R7: PCI slots not in packet, change ignored
        pci_int = 4'h3;
        count_drive(6, drives);
        check("R7 masked pci change", drives, 0);

        // R7: ISA change triggers one-clock pulse
        irq_req = 16'h0021;
        tick();
        @(negedge clk);
        check("R7 pulse low", {30'd0, ser_oe, ser_line}, 32'h2);
        tick();
        host_low = 1'b1;
        @(negedge clk);
        check("R7 pulse one clock", {31'd0, ser_oe}, 32'd0);
        tick();
        run_packet(3, 3, 16, got, bad_rec, bad_frame);
        check("R7 packet after pulse", {12'd0, got}, 32'h00021);
        check("R3 recovery quiet packet", bad_rec, 0);

        // R6: stop of three lows returns to continuous mode
        irq_req = 16'h0200;
        count_drive(8, drives);
        check("R6 continuous after three-low stop", drives, 0);

        // R1: reset while quiet returns to continuous
        run_packet(4, 2, 16, got, bad_rec, bad_frame);
        check("R6 quiet again slots", {12'd0, got}, 32'h00200);
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        irq_req = 16'h4000;
        count_drive(8, drives);
        check("R1 reset leaves quiet mode", drives, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule